// File: doc/BRIEF.md
# Automatic Serial Flow Control Unit

This unit sits beside one channel of a serial port. It decides when that channel's transmitter may start a new character, and it tells the far end when the local receive buffer is filling up. Two mechanisms do this. The first uses control characters sent inside the data stream. Received bytes are compared against four programmable 8-bit characters: two resume characters and two pause characters. A match pauses or resumes the local transmitter, and the matched character is not passed on to the receive buffer. In the other direction, when the receive buffer crosses its thresholds, the unit asks the transmit path to send pause or resume characters to the peer.

The second mechanism uses the modem handshake lines. The clear-to-send input can gate the transmitter. The request-to-send output is driven from the receive buffer level with hysteresis. A pause from either source never cuts a character in half: the transmitter finishes the character it is shifting before the gate closes.

An 8-bit feature word configures the unit, and its bit positions are decoded directly. Received characters arrive as single-cycle strobes. Characters to be kept leave on a registered write strobe toward the receive buffer. Characters to be sent to the peer leave through a valid/acknowledge pair.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the outputs are: `tx_en_o`=1, `rts_o`=1, `inj_valid_o`=0, `rx_wr_o`=0 and `spec_o`=0. All four control characters are inputs, so they have no stored reset value.
- R2: When `ctl_i[1:0]`=00 (matching off), every strobed byte on `rx_data_i` appears unchanged on `rx_data_o`, with `rx_wr_o` high, one cycle later. Strobes are at least three cycles apart.
- R3: When `ctl_i[1:0]`=01, a byte equal to `pause1_i` pauses the transmitter and a byte equal to `resume1_i` resumes it. When `ctl_i[1:0]`=10, `pause2_i` and `resume2_i` do the same. A matched byte is never written. Bytes that do not match are written in arrival order.
- R4: When `ctl_i[1:0]`=11, only the two-byte sequence `pause1_i` then `pause2_i` pauses, and only `resume1_i` then `resume2_i` resumes. Both bytes are consumed. If the first byte is not followed by its partner, it is written, and the following byte is then written or starts a new sequence, with order preserved.
- R5: Once a pause is registered and no character is in flight, `tx_en_o` is low on the next cycle. Setting `ctl_i[1:0]`=00 clears a registered pause.
- R6: With `any_resume_i`=1, any written (non-control) byte ends a pause and is still written. With `any_resume_i`=0, such a byte leaves the pause in place.
- R7: With `ctl_i[7]`=1, `cts_i`=0 closes the gate. With `ctl_i[7]`=0, `cts_i` has no effect. No pause source lowers `tx_en_o` while `tx_busy_i`=1. The gate opens only when every enabled pause source has cleared.
- R8: With `ctl_i[6]`=1, `rts_o` falls on the cycle after `rx_level_i` >= `trig_hi_i`. It rises again only after `rx_level_i` <= `trig_lo_i`. With `ctl_i[6]`=0, `rts_o` stays 1.
- R9: When the level crosses upward (as in R8), the unit offers pause characters on `inj_char_o`; after the downward crossing it offers resume characters. The selection is set by `ctl_i[3:2]`: 01 sends set 1, 10 sends set 2, 11 sends set 1 then set 2, and 00 sends nothing. Each character stays stable with `inj_valid_o` high until `inj_ack_i`.
- R10: With `ctl_i[5]`=1, a received byte equal to `pause2_i` gives a one-cycle `spec_o` pulse on the cycle after its strobe. The pulse does not change whether the byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_i | input | 8 | Feature word: [7] auto clear-to-send gating, [6] auto request-to-send, [5] special detect, [3:2] send mode, [1:0] match mode |
| resume1_i | input | 8 | First resume character |
| resume2_i | input | 8 | Second resume character |
| pause1_i | input | 8 | First pause character |
| pause2_i | input | 8 | Second pause character |
| any_resume_i | input | 1 | Let any kept byte end a pause |
| rx_valid_i | input | 1 | Strobe for a newly received byte |
| rx_data_i | input | 8 | Received byte |
| rx_level_i | input | LVL_W | Current receive buffer fill level |
| trig_hi_i | input | LVL_W | Upper threshold |
| trig_lo_i | input | LVL_W | Lower threshold |
| cts_i | input | 1 | Clear-to-send from the peer, 1 = clear |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| inj_ack_i | input | 1 | Transmit path took the offered control character |
| rx_wr_o | output | 1 | Write strobe toward the receive buffer |
| rx_data_o | output | 8 | Byte to write |
| spec_o | output | 1 | Special character seen |
| tx_en_o | output | 1 | Transmitter may start a new character |
| inj_valid_o | output | 1 | A control character is offered |
| inj_char_o | output | 8 | Offered control character |
| rts_o | output | 1 | Request-to-send to the peer, 1 = ready |

## Verification
The interesting collision is a matched resume character arriving in the same cycle that the clear-to-send line drops under automatic gating. One pause source releases while the other engages, so the gate must stay shut. The bench first pauses the channel, then drives the resume byte and the falling clear-to-send input on the same edge. Some cycles later it checks that `tx_en_o` is still low and that the resume byte was consumed rather than written. It then raises clear-to-send and expects the gate to open within two cycles.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    MATCH_NONE = 2'd0,
    MATCH_SET1 = 2'd1,
    MATCH_SET2 = 2'd2,
    MATCH_PAIR = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    SEND_NONE = 2'd0,
    SEND_SET1 = 2'd1,
    SEND_SET2 = 2'd2,
    SEND_PAIR = 2'd3
  } send_mode_e;

  typedef enum logic [1:0] {
    INJ_IDLE   = 2'd0,
    INJ_FIRST  = 2'd1,
    INJ_SECOND = 2'd2
  } inj_state_e;

  localparam int FEAT_CTS  = 7;
  localparam int FEAT_RTS  = 6;
  localparam int FEAT_SPEC = 5;
endpackage

// File: rtl/fc_rx_match.sv
module fc_rx_match
  import fc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  match_mode_e       mode_i,
  input  logic              spec_en_i,
  input  logic              any_resume_i,
  input  logic [CHAR_W-1:0] resume1_i,
  input  logic [CHAR_W-1:0] resume2_i,
  input  logic [CHAR_W-1:0] pause1_i,
  input  logic [CHAR_W-1:0] pause2_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  output logic              rx_wr_o,
  output logic [CHAR_W-1:0] rx_data_o,
  output logic              spec_o,
  output logic              paused_o
);
  // Sequence mode holds back a first byte; a mismatch can release two bytes,
  // the second of which waits one cycle in the spill register.
  logic              hold_q, hold_d;
  logic              hold_pause_q, hold_pause_d;
  logic              spill_q, spill_d;
  logic [CHAR_W-1:0] spill_data_q, spill_data_d;
  logic              paused_q, paused_d;
  logic              wr_d;
  logic [CHAR_W-1:0] wdata_d;
  logic              take_new, consumed;

  always_comb begin
    hold_d       = hold_q;
    hold_pause_d = hold_pause_q;
    spill_d      = 1'b0;
    spill_data_d = spill_data_q;
    paused_d     = paused_q;
    wr_d         = 1'b0;
    wdata_d      = spill_data_q;
    take_new     = 1'b0;
    consumed     = 1'b0;
    if (mode_i == MATCH_NONE) paused_d = 1'b0;
    if (spill_q) begin
      wr_d    = 1'b1;
      wdata_d = spill_data_q;
    end else if (rx_valid_i) begin
      take_new = 1'b1;
      if (hold_q) begin
        hold_d = 1'b0;
        if (mode_i == MATCH_PAIR &&
            (hold_pause_q ? (rx_data_i == pause2_i) : (rx_data_i == resume2_i))) begin
          paused_d = hold_pause_q;
          take_new = 1'b0;
        end else begin
          wr_d    = 1'b1;
          wdata_d = hold_pause_q ? pause1_i : resume1_i;
        end
      end
      if (take_new) begin
        unique case (mode_i)
          MATCH_SET1: begin
            if (rx_data_i == pause1_i) begin
              paused_d = 1'b1; consumed = 1'b1;
            end else if (rx_data_i == resume1_i) begin
              paused_d = 1'b0; consumed = 1'b1;
            end
          end
          MATCH_SET2: begin
            if (rx_data_i == pause2_i) begin
              paused_d = 1'b1; consumed = 1'b1;
            end else if (rx_data_i == resume2_i) begin
              paused_d = 1'b0; consumed = 1'b1;
            end
          end
          MATCH_PAIR: begin
            if (rx_data_i == pause1_i) begin
              hold_d = 1'b1; hold_pause_d = 1'b1; consumed = 1'b1;
            end else if (rx_data_i == resume1_i) begin
              hold_d = 1'b1; hold_pause_d = 1'b0; consumed = 1'b1;
            end
          end
          default: ;
        endcase
        if (!consumed) begin
          if (any_resume_i) paused_d = 1'b0;
          if (wr_d) begin
            spill_d      = 1'b1;
            spill_data_d = rx_data_i;
          end else begin
            wr_d    = 1'b1;
            wdata_d = rx_data_i;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q       <= 1'b0;
      hold_pause_q <= 1'b0;
      spill_q      <= 1'b0;
      spill_data_q <= '0;
      paused_q     <= 1'b0;
      rx_wr_o      <= 1'b0;
      rx_data_o    <= '0;
      spec_o       <= 1'b0;
    end else begin
      hold_q       <= hold_d;
      hold_pause_q <= hold_pause_d;
      spill_q      <= spill_d;
      spill_data_q <= spill_data_d;
      paused_q     <= paused_d;
      rx_wr_o      <= wr_d;
      rx_data_o    <= wdata_d;
      spec_o       <= spec_en_i & rx_valid_i & (rx_data_i == pause2_i);
    end
  end

  assign paused_o = paused_q;
endmodule

// File: rtl/fc_level_mon.sv
module fc_level_mon #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rts_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_hi_i,
  input  logic [LVL_W-1:0] trig_lo_i,
  output logic             full_o,
  output logic             rts_o
);
  logic full_d;

  always_comb begin
    if (level_i >= trig_hi_i)      full_d = 1'b1;
    else if (level_i <= trig_lo_i) full_d = 1'b0;
    else                           full_d = full_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_o <= 1'b0;
      rts_o  <= 1'b1;
    end else begin
      full_o <= full_d;
      rts_o  <= ~(rts_en_i & full_d);
    end
  end
endmodule

// File: rtl/fc_tx_inject.sv
module fc_tx_inject
  import fc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  send_mode_e        mode_i,
  input  logic              full_i,
  input  logic [CHAR_W-1:0] resume1_i,
  input  logic [CHAR_W-1:0] resume2_i,
  input  logic [CHAR_W-1:0] pause1_i,
  input  logic [CHAR_W-1:0] pause2_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] char_o
);
  inj_state_e state_q;
  send_mode_e mode_q;
  logic       sent_full_q;
  logic       target_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= INJ_IDLE;
      mode_q      <= SEND_NONE;
      sent_full_q <= 1'b0;
      target_q    <= 1'b0;
      valid_o     <= 1'b0;
      char_o      <= '0;
    end else begin
      unique case (state_q)
        INJ_IDLE: begin
          if (mode_i == SEND_NONE) begin
            sent_full_q <= full_i;
          end else if (full_i != sent_full_q) begin
            target_q <= full_i;
            mode_q   <= mode_i;
            valid_o  <= 1'b1;
            state_q  <= INJ_FIRST;
            if (mode_i == SEND_SET2) char_o <= full_i ? pause2_i : resume2_i;
            else                     char_o <= full_i ? pause1_i : resume1_i;
          end
        end
        INJ_FIRST: begin
          if (ack_i) begin
            if (mode_q == SEND_PAIR) begin
              char_o  <= target_q ? pause2_i : resume2_i;
              state_q <= INJ_SECOND;
            end else begin
              valid_o     <= 1'b0;
              sent_full_q <= target_q;
              state_q     <= INJ_IDLE;
            end
          end
        end
        INJ_SECOND: begin
          if (ack_i) begin
            valid_o     <= 1'b0;
            sent_full_q <= target_q;
            state_q     <= INJ_IDLE;
          end
        end
        default: state_q <= INJ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic cts_gate_en_i,
  input  logic cts_i,
  input  logic sw_paused_i,
  input  logic tx_busy_i,
  output logic tx_en_o
);
  logic stop_req;

  assign stop_req = sw_paused_i | (cts_gate_en_i & ~cts_i);

  // Closing waits for the gap between characters; opening is immediate.
  always_ff @(posedge clk) begin
    if (rst)             tx_en_o <= 1'b1;
    else if (!stop_req)  tx_en_o <= 1'b1;
    else if (!tx_busy_i) tx_en_o <= 1'b0;
  end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import fc_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        ctl_i,
  input  logic [CHAR_W-1:0] resume1_i,
  input  logic [CHAR_W-1:0] resume2_i,
  input  logic [CHAR_W-1:0] pause1_i,
  input  logic [CHAR_W-1:0] pause2_i,
  input  logic              any_resume_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  trig_hi_i,
  input  logic [LVL_W-1:0]  trig_lo_i,
  input  logic              cts_i,
  input  logic              tx_busy_i,
  input  logic              inj_ack_i,
  output logic              rx_wr_o,
  output logic [CHAR_W-1:0] rx_data_o,
  output logic              spec_o,
  output logic              tx_en_o,
  output logic              inj_valid_o,
  output logic [CHAR_W-1:0] inj_char_o,
  output logic              rts_o
);
  logic rx_paused;
  logic rx_full;
  logic unused_ctl_bit;

  assign unused_ctl_bit = ctl_i[4];

  fc_rx_match #(.CHAR_W(CHAR_W)) u_match (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (match_mode_e'(ctl_i[1:0])),
    .spec_en_i   (ctl_i[FEAT_SPEC]),
    .any_resume_i(any_resume_i),
    .resume1_i   (resume1_i),
    .resume2_i   (resume2_i),
    .pause1_i    (pause1_i),
    .pause2_i    (pause2_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .rx_wr_o     (rx_wr_o),
    .rx_data_o   (rx_data_o),
    .spec_o      (spec_o),
    .paused_o    (rx_paused)
  );

  fc_level_mon #(.LVL_W(LVL_W)) u_level (
    .clk      (clk),
    .rst      (rst),
    .rts_en_i (ctl_i[FEAT_RTS]),
    .level_i  (rx_level_i),
    .trig_hi_i(trig_hi_i),
    .trig_lo_i(trig_lo_i),
    .full_o   (rx_full),
    .rts_o    (rts_o)
  );

  fc_tx_inject #(.CHAR_W(CHAR_W)) u_inject (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (send_mode_e'(ctl_i[3:2])),
    .full_i   (rx_full),
    .resume1_i(resume1_i),
    .resume2_i(resume2_i),
    .pause1_i (pause1_i),
    .pause2_i (pause2_i),
    .ack_i    (inj_ack_i),
    .valid_o  (inj_valid_o),
    .char_o   (inj_char_o)
  );

  fc_tx_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .cts_gate_en_i(ctl_i[FEAT_CTS]),
    .cts_i        (cts_i),
    .sw_paused_i  (rx_paused),
    .tx_busy_i    (tx_busy_i),
    .tx_en_o      (tx_en_o)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int LVL_W  = 7,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        ctl_i,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic [LVL_W-1:0]  trig_hi_i,
  input logic              cts_i,
  input logic              tx_busy_i,
  input logic              inj_ack_i,
  input logic              inj_valid_o,
  input logic [CHAR_W-1:0] inj_char_o,
  input logic              tx_en_o,
  input logic              rts_o,
  input logic              rx_paused
);
  assert_paused_closes_R5: assert property (@(posedge clk) disable iff (rst)
    rx_paused && !tx_busy_i |=> !tx_en_o);

  assert_cts_closes_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_i[7] && !cts_i && !tx_busy_i |=> !tx_en_o);

  assert_no_midchar_close_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en_o) |-> !$past(tx_busy_i));

  assert_rts_drop_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_i[6] && (rx_level_i >= trig_hi_i) |=> !rts_o);

  assert_rts_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl_i[6] |=> rts_o);

  assert_inj_hold_R9: assert property (@(posedge clk) disable iff (rst)
    inj_valid_o && !inj_ack_i |=> inj_valid_o && $stable(inj_char_o));
endmodule

bind uart_flow_ctrl fc_checker #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_i      (ctl_i),
  .rx_level_i (rx_level_i),
  .trig_hi_i  (trig_hi_i),
  .cts_i      (cts_i),
  .tx_busy_i  (tx_busy_i),
  .inj_ack_i  (inj_ack_i),
  .inj_valid_o(inj_valid_o),
  .inj_char_o (inj_char_o),
  .tx_en_o    (tx_en_o),
  .rts_o      (rts_o),
  .rx_paused  (rx_paused)
);

// File: tb/uart_flow_ctrl_tb.sv
module uart_flow_ctrl_tb;
  localparam int LVL_W = 7;
  localparam logic [7:0] RES1 = 8'h11, PAU1 = 8'h13, RES2 = 8'hA1, PAU2 = 8'hA3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1;
  logic [7:0]       ctl = 8'h00;
  logic             any_resume = 1'b0;
  logic             rx_valid = 1'b0;
  logic [7:0]       rx_data = 8'h00;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] trig_hi = LVL_W'(8);
  logic [LVL_W-1:0] trig_lo = LVL_W'(4);
  logic             cts = 1'b1;
  logic             tx_busy = 1'b0;
  logic             inj_ack = 1'b0;
  logic             rx_wr, spec, tx_en, inj_valid, rts;
  logic [7:0]       rx_dout, inj_char;

  uart_flow_ctrl #(.LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst(rst), .ctl_i(ctl),
    .resume1_i(RES1), .resume2_i(RES2), .pause1_i(PAU1), .pause2_i(PAU2),
    .any_resume_i(any_resume), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_level_i(rx_level), .trig_hi_i(trig_hi), .trig_lo_i(trig_lo),
    .cts_i(cts), .tx_busy_i(tx_busy), .inj_ack_i(inj_ack),
    .rx_wr_o(rx_wr), .rx_data_o(rx_dout), .spec_o(spec), .tx_en_o(tx_en),
    .inj_valid_o(inj_valid), .inj_char_o(inj_char), .rts_o(rts)
  );

  int n_vec = 0, n_bad = 0, spec_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_rx[$];
  logic [7:0] exp_inj[$];
  logic [7:0] want;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    rx_data  = d;
    rx_valid = 1'b1;
    tick(1);
    rx_valid = 1'b0;
    tick(3);
  endtask

  // Monitor: receive-buffer writes, control-character offers, special pulses.
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_wr) begin
        if (exp_rx.size() == 0) chk(1'b0, "R3 unexpected kept byte", rx_dout, 0);
        else begin
          want = exp_rx.pop_front();
          chk(rx_dout == want, "R2 kept byte", rx_dout, want);
        end
      end
      if (spec) spec_cnt++;
      inj_ack <= 1'b0;
      if (inj_valid && !inj_ack) begin
        if (exp_inj.size() == 0) chk(1'b0, "R9 unexpected control char", inj_char, 0);
        else begin
          want = exp_inj.pop_front();
          chk(inj_char == want, "R9 control char", inj_char, want);
        end
        inj_ack <= 1'b1;
      end
    end
  end

  task automatic drained(input string req);
    tick(2);
    chk(exp_rx.size() == 0, req, exp_rx.size(), 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    chk(tx_en == 1'b1, "R1 tx_en", tx_en, 1);
    chk(rts == 1'b1, "R1 rts", rts, 1);
    chk(inj_valid == 1'b0, "R1 inj_valid", inj_valid, 0);
    chk(rx_wr == 1'b0 && spec == 1'b0, "R1 rx_wr/spec", rx_wr, 0);
    tick(2);

    // R2 matching off: control characters pass through
    exp_rx.push_back(PAU1); send(PAU1);
    exp_rx.push_back(8'h5A); send(8'h5A);
    drained("R2 pass-through");
    chk(tx_en == 1'b1, "R2 no pause", tx_en, 1);

    // R3 set 1
    ctl[1:0] = 2'b01;
    exp_rx.push_back(8'h41); send(8'h41);
    send(PAU1);
    chk(tx_en == 1'b0, "R3 pause1 closes gate", tx_en, 0);
    drained("R3 pause1 consumed");
    send(RES1);
    chk(tx_en == 1'b1, "R3 resume1 opens gate", tx_en, 1);

    // R7 finish current character before closing
    tx_busy = 1'b1;
    send(PAU1);
    chk(tx_en == 1'b1, "R7 busy holds gate open", tx_en, 1);
    tx_busy = 1'b0;
    tick(2);
    chk(tx_en == 1'b0, "R5 closes after char ends", tx_en, 0);

    // R6 any-resume off then on
    exp_rx.push_back(8'h55); send(8'h55);
    chk(tx_en == 1'b0, "R6 no any-resume", tx_en, 0);
    any_resume = 1'b1;
    exp_rx.push_back(8'h56); send(8'h56);
    chk(tx_en == 1'b1, "R6 any-resume opens", tx_en, 1);
    drained("R6 bytes kept");
    any_resume = 1'b0;

    // R3 set 2
    ctl[1:0] = 2'b10;
    exp_rx.push_back(PAU1); send(PAU1);
    chk(tx_en == 1'b1, "R3 set1 ignored in set2", tx_en, 1);
    send(PAU2);
    chk(tx_en == 1'b0, "R3 pause2 closes", tx_en, 0);
    // R5 mode 00 clears pause
    ctl[1:0] = 2'b00;
    tick(3);
    chk(tx_en == 1'b1, "R5 mode off clears pause", tx_en, 1);
    drained("R3 set2 stream");

    // R4 paired sequences
    ctl[1:0] = 2'b11;
    send(PAU1); send(PAU2);
    chk(tx_en == 1'b0, "R4 pair pauses", tx_en, 0);
    send(RES1); send(RES2);
    chk(tx_en == 1'b1, "R4 pair resumes", tx_en, 1);
    exp_rx.push_back(PAU1); exp_rx.push_back(8'h77);
    send(PAU1); send(8'h77);
    chk(tx_en == 1'b1, "R4 broken pair no pause", tx_en, 1);
    exp_rx.push_back(PAU1);
    send(PAU1); send(PAU1); send(PAU2);
    chk(tx_en == 1'b0, "R4 restarted pair pauses", tx_en, 0);
    drained("R4 released bytes");

    // R7 collision: resume byte and clear-to-send drop on the same edge
    ctl[1:0] = 2'b01; ctl[7] = 1'b1;
    tick(2);
    rx_data = RES1; rx_valid = 1'b1; cts = 1'b0;
    tick(1);
    rx_valid = 1'b0;
    tick(4);
    chk(tx_en == 1'b0, "R7 cts keeps gate shut", tx_en, 0);
    cts = 1'b1;
    tick(2);
    chk(tx_en == 1'b1, "R7 gate opens", tx_en, 1);
    ctl[7] = 1'b0; cts = 1'b0;
    tick(3);
    chk(tx_en == 1'b1, "R7 cts ignored when off", tx_en, 1);
    cts = 1'b1;
    drained("R7 resume consumed");

    // R8 request-to-send hysteresis
    ctl[6] = 1'b1;
    rx_level = LVL_W'(7); tick(2);
    chk(rts == 1'b1, "R8 below high", rts, 1);
    rx_level = LVL_W'(8); tick(2);
    chk(rts == 1'b0, "R8 at high", rts, 0);
    rx_level = LVL_W'(6); tick(2);
    chk(rts == 1'b0, "R8 hysteresis", rts, 0);
    rx_level = LVL_W'(4); tick(2);
    chk(rts == 1'b1, "R8 at low", rts, 1);
    ctl[6] = 1'b0; rx_level = LVL_W'(10); tick(2);
    chk(rts == 1'b1, "R8 disabled", rts, 1);
    rx_level = '0; tick(3);

    // R9 control character injection
    ctl[3:2] = 2'b01;
    exp_inj.push_back(PAU1); rx_level = LVL_W'(9); tick(8);
    exp_inj.push_back(RES1); rx_level = LVL_W'(2); tick(8);
    chk(exp_inj.size() == 0, "R9 set1 sent", exp_inj.size(), 0);
    ctl[3:2] = 2'b11;
    exp_inj.push_back(PAU1); exp_inj.push_back(PAU2); rx_level = LVL_W'(9); tick(10);
    exp_inj.push_back(RES1); exp_inj.push_back(RES2); rx_level = LVL_W'(2); tick(10);
    chk(exp_inj.size() == 0, "R9 pair sent", exp_inj.size(), 0);
    ctl[3:2] = 2'b10;
    exp_inj.push_back(PAU2); rx_level = LVL_W'(9); tick(8);
    chk(exp_inj.size() == 0, "R9 set2 sent", exp_inj.size(), 0);
    ctl[3:2] = 2'b00;
    rx_level = LVL_W'(1); tick(8);
    chk(inj_valid == 1'b0, "R9 mode off sends nothing", inj_valid, 0);

    // R10 special character flag
    ctl[1:0] = 2'b00; ctl[5] = 1'b1;
    spec_cnt = 0;
    exp_rx.push_back(PAU2); send(PAU2);
    chk(spec_cnt == 1, "R10 special pulse", spec_cnt, 1);
    exp_rx.push_back(PAU1); send(PAU1);
    chk(spec_cnt == 1, "R10 other byte no pulse", spec_cnt, 1);
    drained("R10 bytes kept");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule